// File: doc/BRIEF.md
# Buck Converter Protection Supervisor

This block is the digital protection and start-up state machine of a peak-current-mode buck controller. Analog comparators outside it turn the feedback, current-sense, switch-node and supply conditions into single-bit flags. A pulse marks the start of each switching period. From these inputs the block decides whether the power stage may switch, whether the soft-start capacitor is held discharged, whether the low-side switch is forced on to clamp the output, and whether the open-drain power-good pin may be released.

Over-current is handled by a hiccup retry. A run of consecutive tripped periods stops switching for a fixed number of period pulses, and the converter then restarts through soft-start. Two over-voltage latches clamp the output through the low-side switch, and each has its own way to clear:

- The output over-voltage latch clears when the enable request is dropped or the supply is cycled.
- The start-up switch-node over-voltage latch clears only when the supply is cycled.

When several conditions are present, they take effect in this order, from highest to lowest: supply under-voltage, start-up latch, output over-voltage latch, enable request, hiccup, normal run.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While reset is held, and right after it, switching is disabled, soft-start discharge is asserted, the low-side force is off and power-good is low.
- R2: With the supply good, the request high and no fault, switching is enabled and soft-start discharge is released one clock after the inputs are sampled.
- R3: Supply under-voltage disables switching, asserts soft-start discharge and releases the low-side force at the next clock. This also clears both over-voltage latches.
- R4: A low enable request with no latch active disables switching and asserts soft-start discharge at the next clock.
- R5: Feedback at or above 125% while the request is high gives, at the next clock, switching off, low-side force on and soft-start discharge on. This state holds while the request stays high, whatever the feedback does. Dropping the request releases the force at the next clock.
- R6: A switch-node over-voltage flag latches the low-side force with switching off. The flag only counts in the arming window, which opens at reset or at release from under-voltage and closes when switching first starts. The latch ignores enable changes. Once switching has started, the flag has no effect.
- R7: The over-current trip flag (oc_trip_i) seen in OC_LIMIT (default 8) consecutive periods stops switching and asserts soft-start discharge at the clock after the last trip.
- R8: A period boundary pulse that closes a period with no trip clears the trip count. Seven trips, then a clean period, then seven more trips leave the converter running.
- R9: The hiccup off time lasts HICCUP_PULSES (default 1024) period pulses. After 1023 pulses switching is still off. At the clock that samples the 1024th pulse, switching resumes with soft-start released.
- R10: Power-good is released once feedback reaches the 90% flag while running. It holds through the band between the thresholds, and goes low at the next clock on the 80% low flag or the 125% flag. It is low in every state other than normal run.
- R11: Under-voltage takes priority over both latches. Asserting it while a latch is active releases the low-side force at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_i | input | 1 | Control supply below start threshold |
| run_req_i | input | 1 | Enable request, high = run |
| oc_trip_i | input | 1 | Current-sense over-current trip pulse |
| fb_hi_i | input | 1 | Feedback at or above 125% of reference |
| fb_good_i | input | 1 | Feedback at or above 90% of reference |
| fb_low_i | input | 1 | Feedback below 80% of reference |
| sw_hi_i | input | 1 | Switch node above start-up over-voltage level |
| cyc_i | input | 1 | One-clock pulse at each switching period start |
| sw_en_o | output | 1 | Power stage switching allowed |
| ss_dump_o | output | 1 | Hold soft-start node discharged |
| ls_force_o | output | 1 | Force low-side switch on |
| pg_ok_o | output | 1 | 1 = release power-good pin, 0 = pull low |

## Verification
Every state register feeds the outputs directly, so a wrong state shows at the ports one clock after the input that caused it. A wrong over-current count shows as a hiccup that starts one period early or late, or as a converter that keeps running after a clean period should have cleared the count. A wrong hiccup count shifts the restart clock away from the clock that samples the 1024th pulse. A latch that clears under the wrong condition shows as ls_force_o dropping while the enable request is toggled.

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
  parameter int OC_LIMIT      = 8,
  parameter int HICCUP_PULSES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_i,
  input  logic run_req_i,
  input  logic oc_trip_i,
  input  logic fb_hi_i,
  input  logic fb_good_i,
  input  logic fb_low_i,
  input  logic sw_hi_i,
  input  logic cyc_i,
  output logic sw_en_o,
  output logic ss_dump_o,
  output logic ls_force_o,
  output logic pg_ok_o
);

  localparam int OCW = $clog2(OC_LIMIT + 1);
  localparam int HCW = $clog2(HICCUP_PULSES);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_HICCUP, S_OVP, S_PRE} st_t;

  st_t            st, nxt;
  logic           pre_arm, trip_seen, pg_flag;
  logic [OCW-1:0] oc_cnt;
  logic [HCW-1:0] hc_cnt;
  logic           oc_full, hc_done;

  assign oc_full = (st == S_RUN) && oc_trip_i && (oc_cnt == OCW'(OC_LIMIT - 1));
  assign hc_done = (st == S_HICCUP) && cyc_i && (hc_cnt == HCW'(HICCUP_PULSES - 1));

  always_comb begin
    if (uv_i)                                       nxt = S_IDLE;
    else if (st == S_PRE || (pre_arm && sw_hi_i))   nxt = S_PRE;
    else if (run_req_i && (st == S_OVP || fb_hi_i)) nxt = S_OVP;
    else if (!run_req_i)                            nxt = S_IDLE;
    else if (st == S_HICCUP)                        nxt = hc_done ? S_RUN : S_HICCUP;
    else if (oc_full)                               nxt = S_HICCUP;
    else                                            nxt = S_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pre_arm   <= 1'b1;
      oc_cnt    <= '0;
      trip_seen <= 1'b0;
      hc_cnt    <= '0;
      pg_flag   <= 1'b0;
    end else begin
      st <= nxt;

      if (uv_i)              pre_arm <= 1'b1;
      else if (nxt == S_RUN) pre_arm <= 1'b0;

      if (st == S_RUN && nxt == S_RUN) begin
        if (oc_trip_i)               oc_cnt <= oc_cnt + 1'b1;
        else if (cyc_i && !trip_seen) oc_cnt <= '0;
        trip_seen <= cyc_i ? 1'b0 : (trip_seen | oc_trip_i);
      end else begin
        oc_cnt    <= '0;
        trip_seen <= 1'b0;
      end

      if (st != S_HICCUP) hc_cnt <= '0;
      else if (cyc_i)     hc_cnt <= hc_cnt + 1'b1;

      if (st != S_RUN || fb_low_i || fb_hi_i) pg_flag <= 1'b0;
      else if (fb_good_i)                     pg_flag <= 1'b1;
    end
  end

  assign sw_en_o    = (st == S_RUN);
  assign ss_dump_o  = (st != S_RUN);
  assign ls_force_o = (st == S_OVP) || (st == S_PRE);
  assign pg_ok_o    = (st == S_RUN) && pg_flag;

  AST_UV_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (!sw_en_o && ss_dump_o && !ls_force_o)); // R3
  AST_REQ_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_req_i && !ls_force_o) |=> !sw_en_o); // R4
  AST_OVP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_req_i && fb_hi_i) |=> (!sw_en_o && !pg_ok_o)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force_o && !uv_i && run_req_i) |=> ls_force_o); // R5
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && !uv_i) |=> ls_force_o); // R6
  AST_OC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    oc_cnt < OCW'(OC_LIMIT)); // R7
  AST_HICCUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HICCUP && !cyc_i && run_req_i && !uv_i && !fb_hi_i) |=> !sw_en_o); // R9
  AST_PG_LOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fb_low_i |=> !pg_ok_o); // R10

endmodule

// File: tb/tb_buck_fault_supervisor.sv
module tb_buck_fault_supervisor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic uv, run, oc, fbh, fbg, fbl, swh, cyc;
  logic sw_en, ss_dump, ls_force, pg_ok;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  buck_fault_supervisor dut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .run_req_i(run), .oc_trip_i(oc),
    .fb_hi_i(fbh), .fb_good_i(fbg), .fb_low_i(fbl), .sw_hi_i(swh), .cyc_i(cyc),
    .sw_en_o(sw_en), .ss_dump_o(ss_dump), .ls_force_o(ls_force), .pg_ok_o(pg_ok));

  // [15:12] requirement, [11:4] uv run oc fbh fbg fbl swh cyc, [3:0] sw ss ls pg
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    {4'd3,  8'b1100_0000, 4'b0100},  // R3 under-voltage hold
    {4'd4,  8'b0000_0000, 4'b0100},  // R4 request low
    {4'd2,  8'b0100_0000, 4'b1000},  // R2 start
    {4'd6,  8'b0100_0010, 4'b1000},  // R6 switch-node flag ignored once running
    {4'd10, 8'b0100_1000, 4'b1001},  // R10 release
    {4'd10, 8'b0100_0000, 4'b1001},  // R10 hold in band
    {4'd10, 8'b0100_0100, 4'b1000},  // R10 low flag
    {4'd10, 8'b0100_1000, 4'b1001},  // R10 release again
    {4'd5,  8'b0101_0000, 4'b0110},  // R5 trip
    {4'd5,  8'b0100_1000, 4'b0110},  // R5 hold, R10 low outside run
    {4'd5,  8'b0000_0000, 4'b0100},  // R5 request drop clears
    {4'd2,  8'b0100_0000, 4'b1000},  // R2 restart
    {4'd4,  8'b0000_0000, 4'b0100},  // R4
    {4'd3,  8'b1000_0000, 4'b0100},  // R3 supply cycle arms start-up check
    {4'd6,  8'b0000_0010, 4'b0110},  // R6 latch
    {4'd6,  8'b0100_0000, 4'b0110},  // R6 request high ignored
    {4'd6,  8'b0000_0000, 4'b0110},  // R6 request low ignored
    {4'd11, 8'b1000_0000, 4'b0100},  // R11 under-voltage clears latch
    {4'd2,  8'b0100_0000, 4'b1000},  // R2
    {4'd5,  8'b0101_0000, 4'b0110},  // R5
    {4'd11, 8'b1100_0000, 4'b0100},  // R11 under-voltage over output latch
    {4'd2,  8'b0100_0000, 4'b1000}   // R2
  };

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got sw/ss/ls/pg=%b expected %b", req, got, exp);
    end
  endtask

  task automatic tick(input logic t_oc, input logic t_cyc);
    oc = t_oc; cyc = t_cyc;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    {uv, run, oc, fbh, fbg, fbl, swh, cyc} = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {sw_en, ss_dump, ls_force, pg_ok}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {sw_en, ss_dump, ls_force, pg_ok}, 4'b0100);

    for (int i = 0; i < NV; i++) begin
      {uv, run, oc, fbh, fbg, fbl, swh, cyc} = VEC[i][11:4];
      @(negedge clk);
      checks++;
      if ({sw_en, ss_dump, ls_force, pg_ok} !== VEC[i][3:0]) begin
        errors++;
        $display("FAIL R%0d row %0d got %b expected %b", VEC[i][15:12], i,
                 {sw_en, ss_dump, ls_force, pg_ok}, VEC[i][3:0]);
      end
    end

    {uv, oc, fbh, fbg, fbl, swh, cyc} = '0; run = 1'b1;
    for (int i = 0; i < 7; i++) begin tick(1'b1, 1'b0); tick(1'b0, 1'b1); end
    tick(1'b0, 1'b0); tick(1'b0, 1'b1);
    for (int i = 0; i < 7; i++) begin tick(1'b1, 1'b0); tick(1'b0, 1'b1); end
    chk("R8 count cleared by clean period", {sw_en, ss_dump, ls_force, pg_ok}, 4'b1000);
    tick(1'b1, 1'b0);
    chk("R7 eighth consecutive trip", {sw_en, ss_dump, ls_force, pg_ok}, 4'b0100);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 1023; i++) begin tick(1'b0, 1'b1); tick(1'b0, 1'b0); end
    chk("R9 still off after 1023 pulses", {sw_en, ss_dump, ls_force, pg_ok}, 4'b0100);
    tick(1'b0, 1'b1);
    chk("R9 restart on 1024th pulse", {sw_en, ss_dump, ls_force, pg_ok}, 4'b1000);
    tick(1'b0, 1'b0);
    chk("R7 running after hiccup", {sw_en, ss_dump, ls_force, pg_ok}, 4'b1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule